// File: doc/BRIEF.md
# Single-Level Page Table Walker

The walker turns a virtual address from the core into a physical address by fetching one page table entry from memory. A page table register holds the base of the current table, and loading it moves the walker to another address space. When the walker accepts a request, it builds the entry address from that base and the virtual page number. It then reads the entry and checks its valid bit and its owner tag against the current process identifier. It answers with either a physical address or a fault.

The walker also keeps each entry's usage bookkeeping up to date in memory. A successful translation that finds the reference bit clear writes the entry back with that bit set before it responds. A store that finds the dirty bit clear writes the entry back with both bits set. Only one walk is in progress at a time. The request side uses a ready/valid handshake. The memory side is a single-outstanding port that holds its request until it is acknowledged.

Top module: `ptw_walker`

## Requirements
- R1: After reset, req_ready_o is 1, and rsp_valid_o and mem_req_o are 0.
- R2: Each walk starts with one read (mem_we_o = 0) at address base + VPN*4. VPN is req_va_i[31:12] and base is the page table register value at the time the request is accepted. Address and direction stay stable while mem_ack_i is low.
- R3: On a successful walk, rsp_pa_o = {entry[19:0], req_va_i[11:0]} and both fault outputs are 0.
- R4: If the entry's valid bit (bit 31) is 0, the response has rsp_page_fault_o = 1, rsp_prot_fault_o = 0 and rsp_pa_o = 0, and no write-back takes place. This applies whatever the owner tag holds.
- R5: If the entry is valid but its owner tag (bits 28:20) differs from pid_i sampled at acceptance, the response has rsp_prot_fault_o = 1, rsp_page_fault_o = 0 and rsp_pa_o = 0, and nothing is written.
- R6: On a successful load whose entry has the reference bit (bit 29) clear, the entry is written back to the same address with bit 29 set and all other bits unchanged, before the response.
- R7: On a successful store whose entry has the dirty bit (bit 30) clear, the entry is written back with bits 30 and 29 set, before the response.
- R8: No write takes place when the successful access already finds the bits it needs set: bit 29 for a load, bits 29 and 30 for a store.
- R9: req_ready_o is 0 from acceptance until the response. rsp_valid_o is high for exactly one cycle per accepted request.
- R10: Writing the page table register (ptr_we_i) while a walk is busy affects only later walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptr_we_i | input | 1 | Load the page table register |
| ptr_wdata_i | input | 32 | New table base address |
| pid_i | input | 9 | Current process identifier |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker idle, request accepted this cycle |
| req_va_i | input | 32 | Virtual address |
| req_store_i | input | 1 | Access is a store |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_pa_o | output | 32 | Physical address, zero on a fault |
| rsp_page_fault_o | output | 1 | Entry not valid |
| rsp_prot_fault_o | output | 1 | Owner tag mismatch |
| mem_req_o | output | 1 | Memory access requested |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Entry address |
| mem_wdata_o | output | 32 | Updated entry |
| mem_ack_i | input | 1 | Access completed, read data valid |
| mem_rdata_i | input | 32 | Entry read from memory |

## Verification
Some properties are checked by assertions on every cycle. The memory request must hold its address and direction until acknowledged. Every write must carry the reference bit set. A fault must never come with a nonzero address or with both fault kinds at once. The response must last a single cycle, and the walker must not look ready while it uses memory. Other behaviour needs the bench's scenarios. These cover the translated address value and the fault priority of invalid over tag mismatch. They also cover the exact bits written back for loads and stores, the absence of redundant writes, and the effect of changing the table base mid-walk. The bench shows these against its own memory model.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned PTE_W = 32;
  localparam int unsigned TAG_W = 9;
  localparam int unsigned PPN_W = 20;
  localparam int unsigned OFF_W = 12;

  // field order fixes bit positions: 31 valid, 30 dirty, 29 ref, 28:20 tag, 19:0 ppn
  typedef struct packed {
    logic             valid;
    logic             dirty;
    logic             refd;
    logic [TAG_W-1:0] tag;
    logic [PPN_W-1:0] ppn;
  } pte_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CHECK,
    ST_WRITE,
    ST_RESP
  } walk_state_e;
endpackage

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
(
  input  pte_t             pte_i,
  input  logic [TAG_W-1:0] pid_i,
  input  logic             store_i,
  output logic             page_fault_o,
  output logic             prot_fault_o,
  output logic             upd_o,
  output pte_t             pte_o
);
  always_comb begin
    page_fault_o = !pte_i.valid;
    prot_fault_o = pte_i.valid && (pte_i.tag != pid_i);
    pte_o        = pte_i;
    pte_o.refd   = 1'b1;
    if (store_i) pte_o.dirty = 1'b1;
    upd_o = !page_fault_o && !prot_fault_o &&
            (!pte_i.refd || (store_i && !pte_i.dirty));
  end

  always_comb begin
    // R4
    invalid_wins_chk: assert (!(page_fault_o && prot_fault_o));
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_fire_i,
  input  logic        mem_ack_i,
  input  logic        upd_i,
  output walk_state_e state_o
);
  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_fire_i) state_d = ST_READ;
      ST_READ:  if (mem_ack_i)  state_d = ST_CHECK;
      ST_CHECK: state_d = upd_i ? ST_WRITE : ST_RESP;
      ST_WRITE: if (mem_ack_i)  state_d = ST_RESP;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R9
  resp_then_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RESP |=> state_q == ST_IDLE);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PTR_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ptr_we_i,
  input  logic [PTR_W-1:0]     ptr_wdata_i,
  input  logic [TAG_W-1:0]     pid_i,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [VA_W-1:0]      req_va_i,
  input  logic                 req_store_i,
  output logic                 rsp_valid_o,
  output logic [PPN_W+OFF_W-1:0] rsp_pa_o,
  output logic                 rsp_page_fault_o,
  output logic                 rsp_prot_fault_o,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [PTR_W-1:0]     mem_addr_o,
  output logic [PTE_W-1:0]     mem_wdata_o,
  input  logic                 mem_ack_i,
  input  logic [PTE_W-1:0]     mem_rdata_i
);
  localparam int unsigned VPN_W    = VA_W - OFF_W;
  localparam int unsigned PA_W     = PPN_W + OFF_W;
  localparam int unsigned ENTRY_SH = $clog2(PTE_W / 8);

  walk_state_e      state;
  logic [PTR_W-1:0] ptr_q, addr_q;
  logic [OFF_W-1:0] off_q;
  logic [TAG_W-1:0] pid_q;
  logic             store_q;
  pte_t             pte_q, pte_new, wdata_q;
  logic             pf, prot, upd;
  logic [PA_W-1:0]  pa_q;
  logic             pf_q, prot_q;
  logic             req_fire;
  logic [VPN_W-1:0] vpn;

  assign vpn         = req_va_i[VA_W-1:OFF_W];
  assign req_ready_o = (state == ST_IDLE);
  assign req_fire    = req_valid_i && req_ready_o;

  ptw_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_fire_i (req_fire),
    .mem_ack_i  (mem_ack_i),
    .upd_i      (upd),
    .state_o    (state)
  );

  ptw_pte_eval i_eval (
    .pte_i        (pte_q),
    .pid_i        (pid_q),
    .store_i      (store_q),
    .page_fault_o (pf),
    .prot_fault_o (prot),
    .upd_o        (upd),
    .pte_o        (pte_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (ptr_we_i) ptr_q <= ptr_wdata_i;
  end

  // request capture: base taken at acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      off_q   <= '0;
      pid_q   <= '0;
      store_q <= 1'b0;
    end else if (req_fire) begin
      addr_q  <= ptr_q + (PTR_W'(vpn) << ENTRY_SH);
      off_q   <= req_va_i[OFF_W-1:0];
      pid_q   <= pid_i;
      store_q <= req_store_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             pte_q <= '0;
    else if (state == ST_READ && mem_ack_i)  pte_q <= pte_t'(mem_rdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q    <= '0;
      pf_q    <= 1'b0;
      prot_q  <= 1'b0;
      wdata_q <= '0;
    end else if (state == ST_CHECK) begin
      pf_q    <= pf;
      prot_q  <= prot;
      pa_q    <= (pf || prot) ? '0 : {pte_q.ppn, off_q};
      wdata_q <= pte_new;
    end
  end

  assign mem_req_o        = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we_o         = (state == ST_WRITE);
  assign mem_addr_o       = addr_q;
  assign mem_wdata_o      = wdata_q;
  assign rsp_valid_o      = (state == ST_RESP);
  assign rsp_pa_o         = pa_q;
  assign rsp_page_fault_o = pf_q;
  assign rsp_prot_fault_o = prot_q;

  // R2
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R6
  wb_sets_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[29]);

  // R4
  fault_no_pa_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_page_fault_o || rsp_prot_fault_o) |-> rsp_pa_o == '0);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R9
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
endmodule

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
module test_ptw_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ptr_we_i = 1'b0;
  logic [31:0] ptr_wdata_i = '0;
  logic [8:0]  pid_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_va_i = '0;
  logic        req_store_i = 1'b0;
  logic        rsp_valid_o;
  logic [31:0] rsp_pa_o;
  logic        rsp_page_fault_o, rsp_prot_fault_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  always #2.5 clk_i = ~clk_i;

  ptw_walker i_ptw_walker (.*);

  typedef struct {
    logic [31:0] pa;
    logic        pf;
    logic        prot;
    logic [31:0] rd_addr;
  } exp_t;

  exp_t        q[$];
  logic [31:0] mem [logic [31:0]];
  logic [31:0] last_rd;
  int          wr_cnt = 0;
  int          lat = 0;
  int          n_chk = 0, n_fail = 0;

  function automatic logic [31:0] mk(bit v, bit d, bit r, logic [8:0] tag, logic [19:0] ppn);
    return {v, d, r, tag, ppn};
  endfunction

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model, two-cycle latency
  always @(posedge clk_i) begin
    mem_ack_i <= 1'b0;
    if (mem_req_o && !mem_ack_i) begin
      if (lat == 1) begin
        lat <= 0;
        mem_ack_i <= 1'b1;
        if (mem_we_o) begin
          mem[mem_addr_o] = mem_wdata_o;
          wr_cnt++;
        end else begin
          mem_rdata_i <= rd(mem_addr_o);
          last_rd <= mem_addr_o;
        end
      end else lat <= lat + 1;
    end
  end

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && rsp_valid_o) begin
      if (q.size() == 0) chk(0, "R9 unexpected response", 32'h1, 32'h0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(rsp_pa_o == e.pa, "R3 physical address", rsp_pa_o, e.pa);
        chk(rsp_page_fault_o == e.pf, "R4 page fault flag", 32'(rsp_page_fault_o), 32'(e.pf));
        chk(rsp_prot_fault_o == e.prot, "R5 protection flag", 32'(rsp_prot_fault_o), 32'(e.prot));
        chk(last_rd == e.rd_addr, "R2 entry read address", last_rd, e.rd_addr);
      end
    end
  end

  task automatic walk(logic [31:0] va, bit st, logic [31:0] pa, bit pf, bit prot, logic [31:0] ra);
    exp_t e;
    e.pa = pa; e.pf = pf; e.prot = prot; e.rd_addr = ra;
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1; req_va_i = va; req_store_i = st;
    q.push_back(e);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    while (q.size() != 0) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
    summary();
  end

  localparam logic [31:0] TA = 32'h0001_0000;
  localparam logic [31:0] TB = 32'h0002_0000;

  initial begin
    int w0;
    mem[TA + 32'h14]      = mk(1, 0, 0, 9'd3, 20'hABCDE);
    mem[TA + 32'h1C]      = mk(0, 0, 0, 9'd3, 20'h11111);
    mem[TA + 32'h20]      = mk(1, 0, 0, 9'd5, 20'h22222);
    mem[TA + 32'h24]      = mk(0, 1, 1, 9'd7, 20'h33333);
    mem[TA + 32'h3FFFFC]  = mk(1, 1, 1, 9'd3, 20'hFEDCB);
    mem[TB + 32'h14]      = mk(1, 1, 1, 9'd3, 20'h55555);
    pid_i = 9'd3;
    #1;
    // R1 reset state
    chk(req_ready_o == 1'b1, "R1 ready in reset", 32'(req_ready_o), 32'h1);
    chk(rsp_valid_o == 1'b0, "R1 no response in reset", 32'(rsp_valid_o), 32'h0);
    chk(mem_req_o == 1'b0, "R1 no mem request in reset", 32'(mem_req_o), 32'h0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    ptr_we_i = 1'b1; ptr_wdata_i = TA;
    @(negedge clk_i);
    ptr_we_i = 1'b0;

    // R6 load with ref clear
    w0 = wr_cnt;
    walk(32'h0000_5123, 0, 32'hABCD_E123, 0, 0, TA + 32'h14);
    chk(wr_cnt == w0 + 1, "R6 one write-back", wr_cnt, w0 + 1);
    chk(rd(TA + 32'h14) == mk(1, 0, 1, 9'd3, 20'hABCDE), "R6 ref set only",
        rd(TA + 32'h14), mk(1, 0, 1, 9'd3, 20'hABCDE));

    // R7 store with dirty clear
    w0 = wr_cnt;
    walk(32'h0000_5FFF, 1, 32'hABCD_EFFF, 0, 0, TA + 32'h14);
    chk(wr_cnt == w0 + 1, "R7 one write-back", wr_cnt, w0 + 1);
    chk(rd(TA + 32'h14) == mk(1, 1, 1, 9'd3, 20'hABCDE), "R7 dirty and ref set",
        rd(TA + 32'h14), mk(1, 1, 1, 9'd3, 20'hABCDE));

    // R8 no redundant writes
    w0 = wr_cnt;
    walk(32'h0000_5000, 0, 32'hABCD_E000, 0, 0, TA + 32'h14);
    walk(32'h0000_5004, 1, 32'hABCD_E004, 0, 0, TA + 32'h14);
    chk(wr_cnt == w0, "R8 no write when bits set", wr_cnt, w0);

    // R4 invalid entry, and invalid with foreign tag
    w0 = wr_cnt;
    walk(32'h0000_7ABC, 1, 32'h0, 1, 0, TA + 32'h1C);
    walk(32'h0000_9ABC, 0, 32'h0, 1, 0, TA + 32'h24);
    chk(wr_cnt == w0, "R4 no write on page fault", wr_cnt, w0);
    chk(rd(TA + 32'h1C) == mk(0, 0, 0, 9'd3, 20'h11111), "R4 entry untouched",
        rd(TA + 32'h1C), mk(0, 0, 0, 9'd3, 20'h11111));

    // R5 tag mismatch, then matching pid
    w0 = wr_cnt;
    walk(32'h0000_8010, 1, 32'h0, 0, 1, TA + 32'h20);
    chk(wr_cnt == w0, "R5 no write on protection fault", wr_cnt, w0);
    pid_i = 9'd5;
    walk(32'h0000_8010, 0, 32'h2222_2010, 0, 0, TA + 32'h20);
    pid_i = 9'd3;

    // R2 highest page number
    walk(32'hFFFF_F7A5, 0, 32'hFEDC_B7A5, 0, 0, TA + 32'h3FFFFC);

    // R9 busy and R10 base change mid-walk
    @(negedge clk_i);
    req_valid_i = 1'b1; req_va_i = 32'h0000_5321; req_store_i = 1'b0;
    q.push_back('{32'hABCD_E321, 1'b0, 1'b0, TA + 32'h14});
    @(negedge clk_i);
    req_valid_i = 1'b0;
    ptr_we_i = 1'b1; ptr_wdata_i = TB;
    chk(req_ready_o == 1'b0, "R9 not ready while busy", 32'(req_ready_o), 32'h0);
    @(negedge clk_i);
    ptr_we_i = 1'b0;
    chk(req_ready_o == 1'b0, "R9 still busy", 32'(req_ready_o), 32'h0);
    while (q.size() != 0) @(negedge clk_i);
    chk(rsp_valid_o == 1'b0, "R9 single-cycle response", 32'(rsp_valid_o), 32'h0);
    walk(32'h0000_5321, 0, 32'h5555_5321, 0, 0, TB + 32'h14);
    chk(req_ready_o == 1'b1, "R10 idle after new-table walk", 32'(req_ready_o), 32'h1);

    repeat (4) @(negedge clk_i);
    summary();
  end
endmodule